// File: doc/BRIEF.md
# RTC Alarm Interrupt Controller

This block keeps the control byte of a real-time clock and the sticky status flags of its two time-of-day alarms and its oscillator-stop detector. An external time comparator sends a one-cycle match pulse per alarm. The block latches each pulse into a flag and turns the flags into two active-low interrupt pins. A mode bit decides whether the alarms share the first pin or use one pin each. The second pin can instead carry a free-running 32 kHz clock.

Software reaches the block over a simple synchronous register bus. Writes happen on the strobe, and read data is returned combinationally for the address on the bus. The control byte sits at 0x0F and the status byte at 0x10. Two control bits leave the block directly: one stops the oscillator while the clock runs on its backup supply, and one enables the oscillator glitch filter.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The control byte at address 0x0F can be written and read back. Its bits are 7 osc_off_bkup, 6 unused, 5 osf_disable, 4 glitch_en, 3 sqw_en, 2 route_sep, 1 a1_ie and 0 a0_ie. Bit 6 always reads 0, and writes to it are ignored.
- R2: After an asynchronous reset the control byte is 0x80, all flags are 0 and both interrupt pins are high.
- R3: osc_off_bkup_o follows control bit 7 and glitch_en_o follows control bit 4.
- R4: A pulse on match_i[k] sets alarm flag k at the next clock edge, whatever the enable bits hold.
- R5: The status byte at 0x10 holds bit 7 OSF, bit 1 alarm flag 1 and bit 0 alarm flag 0, and its other bits read 0. Writing 0 to a flag bit clears that flag. Writing 1 leaves it unchanged. A set event in the same cycle beats the clear. flags_o is {OSF, flag1, flag0}.
- R6: With route_sep=1, int_n_o[0] is low exactly when a0_ie and flag0 are both 1. int_n_o[1] (when sqw_en=0) is low exactly when a1_ie and flag1 are both 1.
- R7: With route_sep=0, int_n_o[0] is low exactly when a0_ie=1, a1_ie=1 and at least one alarm flag is set. int_n_o[1] stays high while sqw_en=0.
- R8: With sqw_en=1, int_n_o[1] equals clk32_i, in place of any alarm function.
- R9: While osf_disable=1, OSF is 0 from the next edge on and ignores osc_stop_i. While osf_disable=0, a high osc_stop_i sets OSF at the next edge.
- R10: Reads from any address other than 0x0F or 0x10 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and flag clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i |
| match_i | input | 2 | Per-alarm match pulse |
| clk32_i | input | 1 | Free-running 32 kHz clock |
| osc_stop_i | input | 1 | Oscillator-stop detect |
| int_n_o | output | 2 | Active-low interrupt pins |
| osc_off_bkup_o | output | 1 | Stop oscillator on backup supply |
| glitch_en_o | output | 1 | Oscillator glitch-filter enable |
| flags_o | output | 3 | {OSF, alarm flag 1, alarm flag 0} |

## Verification
Every output depends directly on one control register and three flag flops, so a wrong internal bit shows up at the ports within one cycle. A lost or stuck flag appears on flags_o at the edge after the match or clear. A wrong routing or enable bit shows up on int_n_o as soon as a flag is set under the affected mode. The bench tracks the control byte and the flags in a behavioural model and compares every output on every cycle. It walks both routing modes, every enable combination, the square-wave override, a clear and a set in the same cycle, and the oscillator-stop disable.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_ALARM = 2;
  localparam logic [DATA_W-1:0] CTRL_RST = 8'h80;
  localparam int unsigned STAT_OSF_BIT = 7;

  typedef struct packed {
    logic osc_off_bkup;
    logic unused6;
    logic osf_disable;
    logic glitch_en;
    logic sqw_en;
    logic route_sep;
    logic a1_ie;
    logic a0_ie;
  } ctrl_t;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
    end else if (wr_i) begin
      ctrl_q         <= ctrl_t'(wdata_i);
      ctrl_q.unused6 <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  a_r1_bit6_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.unused6);
  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ctrl_q.a0_ie == $past(wdata_i[0])) && (ctrl_q.osc_off_bkup == $past(wdata_i[7])));
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
#(
  parameter int unsigned N = NUM_ALARM
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] match_i,
  input  logic [N-1:0] clr_i,
  input  logic         osc_stop_i,
  input  logic         osf_clr_i,
  input  logic         osf_dis_i,
  output logic [N-1:0] alarm_flag_o,
  output logic         osf_o
);
  logic [N-1:0] flag_q;
  logic         osf_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // set wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= match_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    a_r4_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i[i] |=> flag_q[i]);
    a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !match_i[i]) |=> !flag_q[i]);
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        osf_q <= 1'b0;
    else if (osf_dis_i) osf_q <= 1'b0;
    else                osf_q <= osc_stop_i | (osf_q & ~osf_clr_i);
  end

  assign alarm_flag_o = flag_q;
  assign osf_o        = osf_q;

  a_r9_osf_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osf_dis_i |=> !osf_q);
  a_r9_osf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osf_dis_i && osc_stop_i) |=> osf_q);
endmodule

// File: rtl/rtc_irq_route.sv
module rtc_irq_route
  import rtc_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ctrl_t      ctrl_i,
  input  logic [1:0] alarm_flag_i,
  input  logic       clk32_i,
  output logic [1:0] int_n_o
);
  logic req0, req1;

  always_comb begin
    if (ctrl_i.route_sep) begin
      req0 = ctrl_i.a0_ie & alarm_flag_i[0];
      req1 = ctrl_i.a1_ie & alarm_flag_i[1];
    end else begin
      req0 = ctrl_i.a0_ie & ctrl_i.a1_ie & (|alarm_flag_i);
      req1 = 1'b0;
    end
  end

  assign int_n_o[0] = ~req0;
  assign int_n_o[1] = ctrl_i.sqw_en ? clk32_i : ~req1;

  a_r7_pin1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.route_sep && !ctrl_i.sqw_en) |-> int_n_o[1]);
  a_r6_pin0_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_flag_i == 2'b00) |-> int_n_o[0]);
  a_r8_square: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.sqw_en |-> (int_n_o[1] == clk32_i));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        match_i,
  input  logic              clk32_i,
  input  logic              osc_stop_i,
  output logic [1:0]        int_n_o,
  output logic              osc_off_bkup_o,
  output logic              glitch_en_o,
  output logic [2:0]        flags_o
);
  ctrl_t      ctrl;
  logic [1:0] aflag;
  logic       osf;
  logic       sel_ctrl, sel_stat;

  assign sel_ctrl = (addr_i == CTRL_ADDR);
  assign sel_stat = (addr_i == STAT_ADDR);

  rtc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i & sel_ctrl),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl)
  );

  rtc_flag_bank #(.N(2)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .match_i      (match_i),
    .clr_i        ({2{we_i & sel_stat}} & ~wdata_i[1:0]),
    .osc_stop_i   (osc_stop_i),
    .osf_clr_i    (we_i & sel_stat & ~wdata_i[STAT_OSF_BIT]),
    .osf_dis_i    (ctrl.osf_disable),
    .alarm_flag_o (aflag),
    .osf_o        (osf)
  );

  rtc_irq_route u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_i       (ctrl),
    .alarm_flag_i (aflag),
    .clk32_i      (clk32_i),
    .int_n_o      (int_n_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o = ctrl;
    else if (sel_stat) rdata_o = {osf, 5'b0, aflag};
  end

  assign osc_off_bkup_o = ctrl.osc_off_bkup;
  assign glitch_en_o    = ctrl.glitch_en;
  assign flags_o        = {osf, aflag};

  a_r1_read_bit6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[6]);
  a_r10_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ctrl && !sel_stat) |-> (rdata_o == '0));
  a_r10_ctrl_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_ctrl) |=> $stable(ctrl));
endmodule

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  logic       clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       we = 0;
  logic [1:0] match = 0;
  logic       clk32 = 0, osc_stop = 0;
  logic [7:0] rdata;
  logic [1:0] int_n;
  logic       osc_off, gfil;
  logic [2:0] flags;
  int errors = 0, checks = 0, cyc = 0, c32 = 0;
  bit  done = 0;

  // model state
  logic [7:0] m_ctrl;
  logic       m_f0, m_f1, m_osf;

  always #5 clk = ~clk;

  rtc_alarm_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .match_i(match), .clk32_i(clk32), .osc_stop_i(osc_stop),
    .int_n_o(int_n), .osc_off_bkup_o(osc_off), .glitch_en_o(gfil), .flags_o(flags)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    c32 <= (c32 == 2) ? 0 : c32 + 1;
    if (c32 == 2) clk32 <= ~clk32;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h80; m_f0 = 0; m_f1 = 0; m_osf = 0;
    end else begin
      automatic bit ws = we && addr == 8'h10;
      automatic logic [7:0] nc = (we && addr == 8'h0F) ? (wdata & 8'hBF) : m_ctrl;
      automatic logic nf0 = match[0] || (m_f0 && !(ws && !wdata[0]));
      automatic logic nf1 = match[1] || (m_f1 && !(ws && !wdata[1]));
      automatic logic no = m_ctrl[5] ? 1'b0 : (osc_stop || (m_osf && !(ws && !wdata[7])));
      m_ctrl = nc; m_f0 = nf0; m_f1 = nf1; m_osf = no;
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    automatic bit sep = m_ctrl[2], a0 = m_ctrl[0], a1 = m_ctrl[1], sq = m_ctrl[3];
    automatic logic e0 = sep ? !(a0 && m_f0) : !(a0 && a1 && (m_f0 || m_f1));
    automatic logic e1 = sq ? clk32 : (sep ? !(a1 && m_f1) : 1'b1);
    check("R4 R5 R9 flags", flags, {m_osf, m_f1, m_f0});
    check("R3 osc_off", osc_off, m_ctrl[7]);
    check("R3 glitch", gfil, m_ctrl[4]);
    check(sep ? "R6 int0" : "R7 int0", int_n[0], e0);
    check(sq ? "R8 int1" : (sep ? "R6 int1" : "R7 int1"), int_n[1], e1);
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1; addr = a; wdata = d; we = 1;
    @(negedge clk); #1; we = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); #1; addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk); #1; match = m;
    @(negedge clk); #1; match = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 int pins reset", int_n, 2'b11);
    check("R2 flags reset", flags, 0);
    rst_n = 1;
    rd("R2 ctrl reset", 8'h0F, 8'h80);
    rd("R2 stat reset", 8'h10, 8'h00);
    // R1 layout and bit6
    wr(8'h0F, 8'hFF);
    rd("R1 bit6 ignored", 8'h0F, 8'hBF);
    wr(8'h0F, 8'h13);
    rd("R1 readback", 8'h0F, 8'h13);
    // R4 flags set with enables off
    wr(8'h0F, 8'h04);
    pulse(2'b01);
    rd("R4 flag0 set disabled", 8'h10, 8'h01);
    check("R6 int0 disabled stays high", int_n[0], 1);
    pulse(2'b10);
    rd("R4 flag1 set", 8'h10, 8'h03);
    // R6 separate routing
    wr(8'h0F, 8'h05);
    rd("R6 a0 only", 8'h0F, 8'h05);
    check("R6 int0 low", int_n[0], 0);
    check("R6 int1 high", int_n[1], 1);
    wr(8'h0F, 8'h06);
    @(negedge clk); #1;
    check("R6 int1 low", int_n[1], 0);
    // R5 clear by writing 0, write 1 no effect
    wr(8'h10, 8'hFE);
    rd("R5 clear flag0 only", 8'h10, 8'h02);
    wr(8'h10, 8'hFF);
    rd("R5 write1 keeps", 8'h10, 8'h02);
    // R7 shared routing
    wr(8'h0F, 8'h01);
    @(negedge clk); #1;
    check("R7 needs both enables", int_n[0], 1);
    wr(8'h0F, 8'h03);
    @(negedge clk); #1;
    check("R7 int0 from flag1", int_n[0], 0);
    check("R7 int1 idle", int_n[1], 1);
    // R5 set wins over clear
    @(negedge clk); #1; addr = 8'h10; wdata = 8'h00; we = 1; match = 2'b01;
    @(negedge clk); #1; we = 0; match = 0;
    rd("R5 set beats clear", 8'h10, 8'h01);
    // R8 square wave
    wr(8'h0F, 8'h0E);
    repeat (8) @(negedge clk);
    // R9 oscillator stop
    @(negedge clk); #1; osc_stop = 1;
    @(negedge clk); #1; osc_stop = 0;
    rd("R9 osf set", 8'h10, 8'h81);
    wr(8'h0F, 8'h20);
    @(negedge clk); #1; osc_stop = 1;
    repeat (3) @(negedge clk);
    #1; osc_stop = 0;
    rd("R9 osf held low", 8'h10, 8'h01);
    // R10 other addresses
    wr(8'h07, 8'hFF);
    wr(8'h11, 8'h00);
    rd("R10 read other", 8'h07, 8'h00);
    rd("R10 ctrl untouched", 8'h0F, 8'h20);
    rd("R10 stat untouched", 8'h10, 8'h01);
    // reset mid-run
    @(negedge clk); #1; rst_n = 0; #1;
    check("R2 async reset flags", flags, 0);
    @(negedge clk); #1; rst_n = 1;
    rd("R2 ctrl after reset", 8'h0F, 8'h80);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule